// File: doc/BRIEF.md
# SPI Master Byte Transfer Sequencer

This block carries out one SPI master transfer as a sequence of 8-bit words. Software writes a control word, a total word count and a transmit word count through a small register write port. It then sets the start bit. The block clocks the requested number of words on SCLK/MOSI and samples MISO. The first words come from a transmit FIFO interface. The remaining words are sent as zero filler. Each received word is pushed to a receive FIFO interface unless receive discard is selected, which keeps the receive side empty on write-only transfers. When the last word has been shifted, the start bit drops by itself and a completion flag is raised. The flag stays set until software clears it.

The FIFOs and the clock divider sit outside the block. Each pulse on `sclk_tick` advances SCLK by one half period. If the transmit FIFO is empty when a word is due from it, the block waits with SCLK parked at its idle level. Up to four chip-select lines are decoded from an index. A selected line is either asserted for the whole transfer or driven straight from a level bit under software control.

Top module: `spi_xfer_seq`

## Requirements
- R1: Control word fields are: clock phase at bit 0, clock idle level at bit 1, select polarity at bit 2 (1 = asserted high, 0 = asserted low), select index at bits [5:4], manual select at bit 6, manual level at bit 7, receive discard at bit 8, LSB-first at bit 12 and start at bit 31. Other bits read back 0. Register addresses are 0 control, 1 total count, 2 transmit count and 3 status. After reset the control and status read 0, SCLK is low and all select lines are high.
- R2: SCLK rests at the idle level from bit 1. Each word is exactly 8 SCLK pulses. With phase 0, MISO is sampled on the leading edge and MOSI changes on the trailing edge. With phase 1, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R3: Words leave and enter MSB first when bit 12 is 0 and LSB first when it is 1.
- R4: Exactly the total count of words is clocked (counts are 24 bits). The first min(transmit count, total count) words are popped from the transmit FIFO in order. Any later words are sent as 0x00.
- R5: Each clocked word is pushed to the receive FIFO once, in order, unless receive discard is set, in which case nothing is pushed.
- R6: When the last word ends, start (bit 31) reads 0 and status bit 12 reads 1. Writing 1 to status bit 12 clears it. A start with a total count of 0 completes with no SCLK activity.
- R7: While a word is due from an empty transmit FIFO, SCLK holds its idle level, no further word is clocked and the transfer does not complete. Shifting resumes once data arrives.
- R8: In automatic mode only the indexed select line is asserted, and only while a transfer is running. All other lines sit at the inactive level.
- R9: In manual mode the indexed line is driven to the manual level bit. The other lines sit at the inactive level.
- R10: Register writes other than the status clear are ignored while a transfer runs, including writing 0 to the start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 total count, 2 transmit count, 3 status) |
| reg_wdata | input | 32 | Register write data |
| ctrl_rd | output | 32 | Current control word |
| status_rd | output | 32 | Status word, bit 12 = transfer complete |
| tx_valid | input | 1 | Transmit FIFO holds a word |
| tx_data | input | 8 | Transmit FIFO head word |
| tx_rd | output | 1 | Pop the transmit FIFO head |
| rx_wr | output | 1 | Push strobe to the receive FIFO |
| rx_data | output | 8 | Received word |
| sclk_tick | input | 1 | Half-period enable from the external divider |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 4 | Chip-select lines |

## Verification
A word counter that skips or repeats a value changes how many 8-pulse groups appear on SCLK and how many FIFO pops occur. This is visible within one word time of the slip, and at the latest when the completion flag rises early or late. A wrong shift or bit-order state corrupts the very next MOSI word and the word pushed back to the receive FIFO, so each transfer compares every serial word against the table value. A sequencer stuck in the wrong state shows either as SCLK moving while the transmit FIFO is empty, or as a start bit that never clears. The bench waits out a deliberate stall to catch the first, and bounds every wait to catch the second.

// File: rtl/spi_xfer_seq_pkg.sv
package spi_xfer_seq_pkg;

    // Register addresses
    localparam logic [1:0] RA_CTRL  = 2'd0;
    localparam logic [1:0] RA_TOTAL = 2'd1;
    localparam logic [1:0] RA_TXCNT = 2'd2;
    localparam logic [1:0] RA_STAT  = 2'd3;

    // Writable control bits
    localparam logic [31:0] CTRL_WMASK = 32'h8000_11F7;
    localparam int          DONE_BIT   = 12;

    typedef struct packed {
        logic        start;
        logic [17:0] rsv_hi;
        logic        lsb_first;
        logic [2:0]  rsv_mid;
        logic        rx_discard;
        logic        man_level;
        logic        man_sel;
        logic [1:0]  sel_idx;
        logic        rsv_lo;
        logic        sel_pol;
        logic        clk_idle;
        logic        clk_phase;
    } ctrl_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_LOAD  = 2'd1,
        SQ_SHIFT = 2'd2
    } seq_state_e;

endpackage

// File: rtl/spi_xfer_shifter.sv
module spi_xfer_shifter #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              word_done,
    output logic [WORD_W-1:0] rx_word
);
    localparam int PH_W  = $clog2(2 * WORD_W);
    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(2 * WORD_W - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

    typedef struct packed {
        logic              busy;
        logic [PH_W-1:0]   ph;
        logic              sclk;
        logic              mosi;
        logic              done;
        logic [WORD_W-1:0] tx;
        logic [WORD_W-1:0] rx;
    } sh_t;

    sh_t q, d;

    function automatic logic pick(input logic [WORD_W-1:0] w, input logic [BIT_W-1:0] k,
                                  input logic lsb);
        return lsb ? w[k] : w[BIT_LAST - k];
    endfunction

    logic [BIT_W-1:0] bit_k;
    logic             leading;
    logic [WORD_W-1:0] rx_in;

    always_comb begin
        bit_k   = q.ph[PH_W-1:1];
        leading = ~q.ph[0];
        rx_in   = lsb_first ? {miso, q.rx[WORD_W-1:1]} : {q.rx[WORD_W-2:0], miso};
        d       = q;
        d.done  = 1'b0;
        if (!q.busy) begin
            d.sclk = cpol;
            if (load) begin
                d.busy = 1'b1;
                d.ph   = '0;
                d.tx   = load_word;
                if (!cpha) d.mosi = pick(load_word, '0, lsb_first);
            end
        end else if (tick) begin
            d.sclk = ~q.sclk;
            if (leading) begin
                if (cpha) d.mosi = pick(q.tx, bit_k, lsb_first);
                else      d.rx   = rx_in;
            end else begin
                if (cpha)                   d.rx   = rx_in;
                else if (bit_k != BIT_LAST) d.mosi = pick(q.tx, bit_k + 1'b1, lsb_first);
            end
            if (q.ph == PH_LAST) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end else begin
                d.ph = q.ph + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk      = q.sclk;
    assign mosi      = q.mosi;
    assign word_done = q.done;
    assign rx_word   = q.rx;

    // R2: after an even number of toggles SCLK is back at its idle level
    p_sclk_home_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (q.sclk == cpol));

endmodule

// File: rtl/spi_xfer_csel.sv
module spi_xfer_csel #(
    parameter int NCS = 4
) (
    input  logic           active,
    input  logic [1:0]     sel_idx,
    input  logic           sel_pol,
    input  logic           man_sel,
    input  logic           man_level,
    output logic [NCS-1:0] cs
);
    for (genvar i = 0; i < NCS; i++) begin : g_line
        logic hit;
        assign hit   = (sel_idx == 2'(i));
        assign cs[i] = man_sel ? (hit ? man_level : ~sel_pol)
                               : ((hit && active) ? sel_pol : ~sel_pol);
    end
endmodule

// File: rtl/spi_xfer_seq.sv
module spi_xfer_seq
    import spi_xfer_seq_pkg::*;
#(
    parameter int NCS    = 4,
    parameter int CNT_W  = 24,
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       ctrl_rd,
    output logic [31:0]       status_rd,
    input  logic              tx_valid,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_rd,
    output logic              rx_wr,
    output logic [WORD_W-1:0] rx_data,
    input  logic              sclk_tick,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NCS-1:0]    spi_cs
);
    typedef struct packed {
        seq_state_e       st;
        ctrl_t            ctrl;
        logic [CNT_W-1:0] total;
        logic [CNT_W-1:0] txcnt;
        logic [CNT_W-1:0] idx;
        logic             done;
    } seq_t;

    seq_t q, d;

    logic              need_tx;
    logic              sh_load;
    logic [WORD_W-1:0] sh_word;
    logic              word_done;

    always_comb begin
        d       = q;
        tx_rd   = 1'b0;
        rx_wr   = 1'b0;
        sh_load = 1'b0;
        need_tx = (q.idx < q.txcnt);
        sh_word = need_tx ? tx_data : '0;

        if (reg_wr && reg_addr == RA_STAT && reg_wdata[DONE_BIT]) d.done = 1'b0;

        unique case (q.st)
            SQ_IDLE: begin
                if (reg_wr) begin
                    unique case (reg_addr)
                        RA_CTRL: begin
                            d.ctrl = ctrl_t'(reg_wdata & CTRL_WMASK);
                            if (reg_wdata[31]) begin
                                if (q.total == '0) begin
                                    d.ctrl.start = 1'b0;
                                    d.done       = 1'b1;
                                end else begin
                                    d.st  = SQ_LOAD;
                                    d.idx = '0;
                                end
                            end
                        end
                        RA_TOTAL: d.total = reg_wdata[CNT_W-1:0];
                        RA_TXCNT: d.txcnt = reg_wdata[CNT_W-1:0];
                        default: ;
                    endcase
                end
            end
            SQ_LOAD: begin
                if (!need_tx || tx_valid) begin
                    sh_load = 1'b1;
                    tx_rd   = need_tx;
                    d.st    = SQ_SHIFT;
                end
            end
            SQ_SHIFT: begin
                if (word_done) begin
                    rx_wr = ~q.ctrl.rx_discard;
                    d.idx = q.idx + 1'b1;
                    if (q.idx + 1'b1 == q.total) begin
                        d.st         = SQ_IDLE;
                        d.ctrl.start = 1'b0;
                        d.done       = 1'b1;
                    end else begin
                        d.st = SQ_LOAD;
                    end
                end
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    spi_xfer_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (sclk_tick),
        .cpol      (q.ctrl.clk_idle),
        .cpha      (q.ctrl.clk_phase),
        .lsb_first (q.ctrl.lsb_first),
        .load      (sh_load),
        .load_word (sh_word),
        .miso      (spi_miso),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .word_done (word_done),
        .rx_word   (rx_data)
    );

    spi_xfer_csel #(.NCS(NCS)) u_csel (
        .active    (q.st != SQ_IDLE),
        .sel_idx   (q.ctrl.sel_idx),
        .sel_pol   (q.ctrl.sel_pol),
        .man_sel   (q.ctrl.man_sel),
        .man_level (q.ctrl.man_level),
        .cs        (spi_cs)
    );

    assign ctrl_rd   = q.ctrl;
    assign status_rd = {{(31-DONE_BIT){1'b0}}, q.done, {DONE_BIT{1'b0}}};

    p_pop_has_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rd |-> tx_valid);

    p_discard_no_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_wr |-> !ctrl_rd[8]);

    p_done_drops_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_rd[DONE_BIT]) |-> !ctrl_rd[31]);

    p_stall_parks_sclk_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SQ_LOAD && $past(q.st) == SQ_LOAD) |-> $stable(spi_sclk));

    p_single_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !q.ctrl.man_sel |-> ($countones(~(spi_cs ^ {NCS{q.ctrl.sel_pol}})) <= 1));

    p_cfg_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != SQ_IDLE) |=> $stable(ctrl_rd[30:0]));

endmodule

// File: tb/spi_xfer_seq_test.sv
`timescale 1ns/1ps
module spi_xfer_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] ctrl_rd, status_rd;
    logic        tx_valid, tx_rd, rx_wr;
    logic [7:0]  tx_data, rx_data;
    logic        sclk_tick = 1'b0;
    logic        spi_sclk, spi_mosi, spi_miso;
    logic [3:0]  spi_cs;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;
    always @(posedge clk) sclk_tick <= ~sclk_tick;

    // transmit FIFO model
    logic [7:0] txq [64];
    int tx_wp = 0;
    int tx_rp = 0;
    assign tx_valid = (tx_wp != tx_rp);
    assign tx_data  = txq[tx_rp[5:0]];
    always @(posedge clk) if (tx_rd) tx_rp <= tx_rp + 1;

    // receive FIFO model
    logic [7:0] rxq [64];
    int rx_n = 0;
    always @(posedge clk) if (rx_wr) begin
        rxq[rx_n[5:0]] <= rx_data;
        rx_n <= rx_n + 1;
    end

    assign spi_miso = ~spi_mosi;

    // serial monitor
    logic m_cpol = 1'b0, m_cpha = 1'b0, m_lsb = 1'b0;
    logic mon_prev = 1'b0;
    logic [7:0] mon_sr = '0;
    int mon_bits = 0;
    int mon_n = 0;
    logic [7:0] monq [64];
    always @(negedge clk) begin
        if (spi_sclk != mon_prev) begin
            if (m_cpha ? (spi_sclk == m_cpol) : (spi_sclk != m_cpol)) begin
                if (m_lsb) mon_sr[mon_bits] = spi_mosi;
                else       mon_sr[7 - mon_bits] = spi_mosi;
                mon_bits = mon_bits + 1;
                if (mon_bits == 8) begin
                    monq[mon_n[5:0]] = mon_sr;
                    mon_n = mon_n + 1;
                    mon_bits = 0;
                end
            end
        end
        mon_prev = spi_sclk;
    end

    spi_xfer_seq uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .ctrl_rd(ctrl_rd), .status_rd(status_rd),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_rd(tx_rd),
        .rx_wr(rx_wr), .rx_data(rx_data), .sclk_tick(sclk_tick),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs(spi_cs)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic regw(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        txq[tx_wp[5:0]] = b;
        tx_wp = tx_wp + 1;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!status_rd[12] && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(status_rd[12], req, status_rd, 32'h1000);
    endtask

    task automatic set_mode(input logic [31:0] c);
        m_cpha = c[0]; m_cpol = c[1]; m_lsb = c[12];
        regw(2'd0, c);
        repeat (3) @(negedge clk);
        mon_bits = 0;
    endtask

    function automatic logic [7:0] pat(input logic [7:0] seed, input int k);
        return seed + 8'(k * 37);
    endfunction

    // {cpha, cpol, lsb, discard, total[7:0], txcnt[7:0], seed[7:0]}
    localparam logic [27:0] VEC [8] = '{
        {4'b0000, 8'd4, 8'd4, 8'h5A},
        {4'b1000, 8'd3, 8'd3, 8'hC3},
        {4'b0110, 8'd5, 8'd5, 8'h81},
        {4'b1110, 8'd2, 8'd2, 8'h17},
        {4'b0000, 8'd6, 8'd2, 8'hE4},
        {4'b1101, 8'd4, 8'd4, 8'h39},
        {4'b0100, 8'd3, 8'd5, 8'h6F},
        {4'b1000, 8'd1, 8'd0, 8'hFF}
    };

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: got %h expected %h", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int base_m, base_r, base_t, pops, total, txc, bad;
        logic [31:0] c, saved;
        logic [7:0] e;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(ctrl_rd == 0, "R1 ctrl reset", ctrl_rd, 0);
        chk(status_rd == 0, "R1 status reset", status_rd, 0);
        chk(spi_sclk == 1'b0, "R1 sclk reset", {31'b0, spi_sclk}, 0);
        chk(spi_cs == 4'hF, "R1 select reset", {28'b0, spi_cs}, 32'hF);

        // R1: field positions and reserved bits
        regw(2'd0, 32'h7FFF_FFF7 & ~32'h0000_0040);
        chk(ctrl_rd == 32'h0000_11B7, "R1 field mask", ctrl_rd, 32'h0000_11B7);
        regw(2'd0, 32'h0);

        // main vectors: R2 R3 R4 R5 R6
        foreach (VEC[v]) begin
            c     = {19'b0, VEC[v][25], 3'b0, VEC[v][24], 6'b0, VEC[v][26], VEC[v][27]};
            total = int'(VEC[v][23:16]);
            txc   = int'(VEC[v][15:8]);
            set_mode(c);
            regw(2'd1, total);
            regw(2'd2, txc);
            tx_wp = tx_rp;
            base_t = tx_rp;
            for (int k = 0; k < txc; k++) push(pat(VEC[v][7:0], k));
            base_m = mon_n; base_r = rx_n;
            regw(2'd0, c | 32'h8000_0000);
            wait_done("R6 completion flag");
            chk(ctrl_rd[31] == 1'b0, "R6 start self-clears", ctrl_rd, c);
            chk(mon_n - base_m == total, "R2 word count", mon_n - base_m, total);
            bad = 0;
            for (int k = 0; k < total; k++) begin
                e = (k < txc) ? pat(VEC[v][7:0], k) : 8'h00;
                if (monq[(base_m + k) % 64] != e) bad++;
            end
            chk(bad == 0, "R3 R4 serial words", bad, 0);
            pops = (txc < total) ? txc : total;
            chk(tx_rp - base_t == pops, "R4 fifo pops", tx_rp - base_t, pops);
            if (VEC[v][24]) begin
                chk(rx_n == base_r, "R5 discard keeps rx empty", rx_n - base_r, 0);
            end else begin
                chk(rx_n - base_r == total, "R5 rx push count", rx_n - base_r, total);
                bad = 0;
                for (int k = 0; k < total; k++) begin
                    e = (k < txc) ? pat(VEC[v][7:0], k) : 8'h00;
                    if (rxq[(base_r + k) % 64] != ~e) bad++;
                end
                chk(bad == 0, "R5 rx words", bad, 0);
            end
            regw(2'd3, 32'h0000_1000);
            chk(status_rd == 0, "R6 flag clear", status_rd, 0);
            tx_wp = tx_rp;
        end

        // R6: zero total count
        set_mode(32'h0);
        regw(2'd1, 0);
        base_m = mon_n;
        regw(2'd0, 32'h8000_0000);
        repeat (4) @(negedge clk);
        chk(status_rd[12] && !ctrl_rd[31], "R6 zero count completes", status_rd, 32'h1000);
        chk(mon_n == base_m, "R6 zero count no clocks", mon_n - base_m, 0);
        regw(2'd3, 32'h0000_1000);

        // R7: stall on empty transmit FIFO
        regw(2'd1, 2); regw(2'd2, 2);
        tx_wp = tx_rp;
        push(8'hA5);
        base_m = mon_n;
        regw(2'd0, 32'h8000_0000);
        while (mon_n == base_m) @(negedge clk);
        bad = 0;
        repeat (60) begin
            @(negedge clk);
            if (spi_sclk != 1'b0) bad++;
        end
        chk(bad == 0, "R7 sclk parked", bad, 0);
        chk(!status_rd[12] && mon_n == base_m + 1, "R7 no progress", mon_n - base_m, 1);
        push(8'h3C);
        wait_done("R7 resume completes");
        chk(monq[(base_m + 1) % 64] == 8'h3C, "R7 late word", monq[(base_m + 1) % 64], 8'h3C);
        regw(2'd3, 32'h0000_1000);

        // R8: automatic select, active low, index 2
        set_mode(32'h0000_0020);
        regw(2'd1, 1); regw(2'd2, 0);
        regw(2'd0, 32'h8000_0020);
        repeat (6) @(negedge clk);
        chk(spi_cs == 4'b1011, "R8 select low during", spi_cs, 4'b1011);
        wait_done("R8 completes");
        chk(spi_cs == 4'hF, "R8 select released", spi_cs, 4'hF);
        regw(2'd3, 32'h0000_1000);
        // R8: active high, index 1
        set_mode(32'h0000_0014);
        chk(spi_cs == 4'b0000, "R8 high pol idle", spi_cs, 4'b0000);
        regw(2'd0, 32'h8000_0014);
        repeat (6) @(negedge clk);
        chk(spi_cs == 4'b0010, "R8 select high during", spi_cs, 4'b0010);
        wait_done("R8 completes high");
        regw(2'd3, 32'h0000_1000);

        // R9: manual select
        set_mode(32'h0000_0070);
        chk(spi_cs == 4'b0111, "R9 manual low", spi_cs, 4'b0111);
        set_mode(32'h0000_00F0);
        chk(spi_cs == 4'b1111, "R9 manual high", spi_cs, 4'b1111);
        set_mode(32'h0000_0074);
        chk(spi_cs == 4'b0000, "R9 manual low high-pol", spi_cs, 4'b0000);
        set_mode(32'h0);

        // R10: writes ignored during a transfer
        regw(2'd1, 3); regw(2'd2, 0);
        base_m = mon_n;
        regw(2'd0, 32'h8000_0002);
        saved = ctrl_rd;
        repeat (4) @(negedge clk);
        regw(2'd0, 32'h0);
        chk(ctrl_rd == saved, "R10 start write 0 ignored", ctrl_rd, saved);
        regw(2'd1, 1);
        wait_done("R10 completes");
        chk(mon_n - base_m == 3, "R10 count write ignored", mon_n - base_m, 3);
        regw(2'd3, 32'h0000_1000);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule